// File: doc/BRIEF.md
# Byte-to-Word Register Bridge

This bridge lets a CPU with an 8-bit data bus reach a peripheral whose registers are 32 bits wide. The peripheral sits behind a single-cycle strobe/acknowledge bus. The bridge claims one 256-byte page of CPU address space. Each 32-bit peripheral register takes four consecutive byte addresses, and the least-significant byte sits at the lowest address. The bridge starts a bus transaction only when software touches the lowest byte of a word.

Writing a word is done in two steps. Software first writes bytes 1 to 3 into three holding registers. It then writes byte 0, and that write launches the 32-bit transfer. Reading a word works the other way round. Reading byte 0 launches a bus read and holds the CPU through its ready line until the acknowledge arrives. The other three bytes are then served from a latched copy of the word.

A small local control register at page offset 0x0B does two jobs. Its bit 0 blocks read strobes. Software sets it around indexed stores, because during those stores the CPU shows the target address one cycle before it raises write. Its bit 1 drives a debug trigger pin.

Top module: `byte_word_bridge`

## Requirements
- R1: Only CPU addresses whose bits 15:8 equal 0xFE are decoded. Accesses anywhere else start no bus cycle, change no bridge state and read back 0x00.
- R2: Byte address 0xFE00+4n+k is byte k of word n, with k=0 being bits 7:0. A transaction for that word drives bus_adr = n (CPU address bits 7:2).
- R3: A bus strobe starts only for page addresses whose bits 1:0 are 00. Accesses at offsets 1 to 3 never start a transaction.
- R4: CPU writes at offsets 1, 2 and 3 with address bit 3 clear load holding bytes 1, 2 and 3. Words 0 and 1 share these holding bytes. The same writes with bit 3 set leave the holding bytes unchanged.
- R5: A CPU write at offset 0 starts a bus write. The written word is {hold3, hold2, hold1, CPU data}, and bus_we is 1.
- R6: A CPU read at offset 0 starts a bus read. In the acknowledge cycle cpu_rdata carries bits 7:0 of the returned word. Later reads at offsets 1 to 3 return bits 15:8, 23:16 and 31:24 of the last word read.
- R7: cpu_rdy is low from the cycle a read starts until the acknowledge cycle. With an acknowledge L cycles after the strobe's first cycle, the read therefore sees L+1 stalled cycles.
- R8: A CPU write to 0xFE0B loads the control byte. While its bit 0 is 1, reads start no strobe and do not stall, but writes still start strobes.
- R9: dbg_trig follows bit 1 of the control byte. It changes only on a write to 0xFE0B.
- R10: After reset the control byte is 0, bus_stb is 0, cpu_rdy is 1 and dbg_trig is 0.
- R11: Once raised, bus_stb stays high until bus_ack. While it is high, bus_adr, bus_we and bus_wdata stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU byte address |
| cpu_we | input | 1 | CPU write enable |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data to CPU |
| cpu_rdy | output | 1 | CPU ready, low to stall |
| bus_stb | output | 1 | Peripheral strobe |
| bus_we | output | 1 | Peripheral write enable |
| bus_adr | output | 6 | Peripheral word index |
| bus_wdata | output | 32 | Peripheral write word |
| bus_rdata | input | 32 | Peripheral read word |
| bus_ack | input | 1 | Peripheral acknowledge |
| dbg_trig | output | 1 | Debug trigger from control bit 1 |

## Verification
Aligned writes and aligned reads are swept over all 64 word indices. The byte values are computed from the index, so a swapped lane, a wrong bus address or a stale holding byte shows up as a value mismatch. Reads rotate the peripheral latency through 0 to 3 cycles. This separates a correct stall count from one that is off by a cycle, and a bypassed acknowledge-cycle byte from a latched one. The remaining stimuli each target one behaviour:
- unaligned, off-page and bit-3-set accesses, where the peripheral's own access counters show that no cycle was started;
- an indexed store done with and without the read mask, to show that the mask blocks the stray read;
- writes of several control values, to check that the trigger pin follows control bit 1.

// File: rtl/bwb_pkg.sv
package bwb_pkg;
  localparam int BYTE_W  = 8;
  localparam int LANES   = 4;
  localparam int WORD_W  = BYTE_W * LANES;
  localparam int OFS_W   = $clog2(LANES);
  localparam int PAGE_W  = 8;
  localparam int ADDR_W  = 16;
  localparam int WIDX_W  = PAGE_W - OFS_W;

  typedef struct packed {
    logic              hit;
    logic [OFS_W-1:0]  ofs;
    logic [WIDX_W-1:0] widx;
    logic              hold_sel;
    logic              ctrl_sel;
  } dec_t;
endpackage

// File: rtl/bwb_decode.sv
module bwb_decode
  import bwb_pkg::*;
#(
  parameter logic [PAGE_W-1:0] PAGE_ID  = 8'hFE,
  parameter logic [PAGE_W-1:0] CTRL_OFS = 8'h0B,
  parameter int                HOLD_BIT = 3
) (
  input  logic [ADDR_W-1:0] cpu_addr,
  output dec_t              dec
);
  always_comb begin
    dec.hit      = (cpu_addr[ADDR_W-1:PAGE_W] == PAGE_ID);
    dec.ofs      = cpu_addr[OFS_W-1:0];
    dec.widx     = cpu_addr[PAGE_W-1:OFS_W];
    dec.hold_sel = dec.hit && (dec.ofs != '0) && !cpu_addr[HOLD_BIT];
    dec.ctrl_sel = dec.hit && (cpu_addr[PAGE_W-1:0] == CTRL_OFS);
  end
endmodule

// File: rtl/bwb_ctrl.sv
module bwb_ctrl
  import bwb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] ctrl_q
);
  logic [BYTE_W-1:0] ctrl_n;

  always_comb begin
    ctrl_n = ctrl_q;
    if (wr_en) ctrl_n = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= ctrl_n;
  end
endmodule

// File: rtl/bwb_lanes.sv
module bwb_lanes
  import bwb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_we,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [BYTE_W-1:0] cpu_wdata,
  input  logic              rd_done,
  input  logic [WORD_W-1:0] bus_rdata,
  output logic [WORD_W-1:0] wr_word,
  output logic [BYTE_W-1:0] rd_byte
);
  logic [WORD_W-1:0] rword_q;
  logic [WORD_W-1:0] rd_src;

  // Holding bytes for lanes 1..LANES-1; lane 0 comes straight from the CPU.
  for (genvar g = 1; g < LANES; g++) begin : g_hold
    logic [BYTE_W-1:0] hold_q;
    logic              hold_en;
    assign hold_en = hold_we && (ofs == OFS_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hold_q <= '0;
      else if (hold_en) hold_q <= cpu_wdata;
    end
    assign wr_word[g*BYTE_W +: BYTE_W] = hold_q;
  end
  assign wr_word[BYTE_W-1:0] = cpu_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rword_q <= '0;
    else if (rd_done) rword_q <= bus_rdata;
  end

  always_comb begin
    rd_src  = rd_done ? bus_rdata : rword_q;
    rd_byte = rd_src[ofs*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/bwb_txn.sv
module bwb_txn
  import bwb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              cpu_we,
  input  logic [WIDX_W-1:0] widx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              bus_ack,
  output logic              bus_stb,
  output logic              bus_we,
  output logic [WIDX_W-1:0] bus_adr,
  output logic [WORD_W-1:0] bus_wdata,
  output logic              go,
  output logic              busy,
  output logic              rd_done
);
  logic              stb_n, we_n;
  logic [WIDX_W-1:0] adr_n;
  logic [WORD_W-1:0] wd_n;
  logic              can_start, load;

  always_comb begin
    can_start = !bus_stb || (bus_ack && bus_we);
    go        = can_start && start_req;
    busy      = bus_stb && !bus_ack;
    rd_done   = bus_stb && bus_ack && !bus_we;
    load      = go;
    stb_n     = bus_stb;
    we_n      = bus_we;
    adr_n     = bus_adr;
    wd_n      = bus_wdata;
    if (go) begin
      stb_n = 1'b1;
      we_n  = cpu_we;
      adr_n = widx;
      wd_n  = wr_word;
    end else if (bus_ack) begin
      stb_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_stb <= 1'b0;
    else        bus_stb <= stb_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_we    <= 1'b0;
      bus_adr   <= '0;
      bus_wdata <= '0;
    end else if (load) begin
      bus_we    <= we_n;
      bus_adr   <= adr_n;
      bus_wdata <= wd_n;
    end
  end

  // R11
  stb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stb && !bus_ack |=> bus_stb && $stable(bus_adr) && $stable(bus_we) && $stable(bus_wdata));
endmodule

// File: rtl/byte_word_bridge.sv
module byte_word_bridge
  import bwb_pkg::*;
#(
  parameter logic [PAGE_W-1:0] PAGE_ID  = 8'hFE,
  parameter logic [PAGE_W-1:0] CTRL_OFS = 8'h0B,
  parameter int                HOLD_BIT = 3,
  parameter int                MASK_BIT = 0,
  parameter int                TRIG_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic              cpu_we,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              cpu_rdy,
  output logic              bus_stb,
  output logic              bus_we,
  output logic [5:0]        bus_adr,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_ack,
  output logic              dbg_trig
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  dec_t              dec;
  logic [BYTE_W-1:0] ctrl_q;
  logic [WORD_W-1:0] wr_word;
  logic [BYTE_W-1:0] rd_byte;
  logic              start_req, go, busy, rd_done;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  bwb_decode #(.PAGE_ID(PAGE_ID), .CTRL_OFS(CTRL_OFS), .HOLD_BIT(HOLD_BIT)) u_dec (
    .cpu_addr (cpu_addr),
    .dec      (dec)
  );

  bwb_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .wr_en  (cpu_we && dec.ctrl_sel),
    .wdata  (cpu_wdata),
    .ctrl_q (ctrl_q)
  );

  bwb_lanes u_lanes (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .hold_we   (cpu_we && dec.hold_sel),
    .ofs       (dec.ofs),
    .cpu_wdata (cpu_wdata),
    .rd_done   (rd_done),
    .bus_rdata (bus_rdata),
    .wr_word   (wr_word),
    .rd_byte   (rd_byte)
  );

  assign start_req = dec.hit && (dec.ofs == '0) && (cpu_we || !ctrl_q[MASK_BIT]);

  bwb_txn u_txn (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start_req (start_req),
    .cpu_we    (cpu_we),
    .widx      (dec.widx),
    .wr_word   (wr_word),
    .bus_ack   (bus_ack),
    .bus_stb   (bus_stb),
    .bus_we    (bus_we),
    .bus_adr   (bus_adr),
    .bus_wdata (bus_wdata),
    .go        (go),
    .busy      (busy),
    .rd_done   (rd_done)
  );

  assign cpu_rdy   = !(busy || (go && !cpu_we));
  assign cpu_rdata = dec.hit ? rd_byte : '0;
  assign dbg_trig  = ctrl_q[TRIG_BIT];

  // R3
  unaligned_no_stb_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !bus_stb && (cpu_addr[1:0] != 2'b00) |=> !bus_stb);
  // R1
  off_page_no_stb_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !bus_stb && (cpu_addr[15:8] != PAGE_ID) |=> !bus_stb);
  // R8
  masked_read_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !bus_stb && ctrl_q[MASK_BIT] && !cpu_we |=> !bus_stb);
  // R7
  read_start_stall_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(bus_stb) && !bus_we |-> $past(!cpu_rdy));
  // R9
  trig_stable_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(cpu_we && cpu_addr == {PAGE_ID, CTRL_OFS}) |=> $stable(dbg_trig));
endmodule

// File: tb/byte_word_bridge_tb.sv
module byte_word_bridge_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        cpu_we;
  logic [7:0]  cpu_wdata;
  logic [7:0]  cpu_rdata;
  logic        cpu_rdy;
  logic        bus_stb, bus_we, bus_ack;
  logic [5:0]  bus_adr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        dbg_trig;

  int checks = 0;
  int errors = 0;
  int lat = 0;
  int cnt = 0;
  int n_rd = 0;
  int n_wr = 0;
  bit done = 0;
  logic [31:0] mem [64];

  always #(CLK_P/2) clk = ~clk;

  byte_word_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rdy(cpu_rdy),
    .bus_stb(bus_stb), .bus_we(bus_we), .bus_adr(bus_adr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .dbg_trig(dbg_trig)
  );

  function automatic logic [31:0] init_word(int i);
    return 32'(i) * 32'h9E37_79B1 ^ 32'h5A00_00C3;
  endfunction

  // Peripheral model: acknowledges lat cycles after the strobe's first cycle.
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ack = 1'b0; cnt = 0;
    end else if (bus_ack) begin
      bus_ack = 1'b0; cnt = 0;
    end else if (bus_stb) begin
      if (cnt == lat) begin
        bus_ack = 1'b1;
        if (bus_we) begin mem[bus_adr] = bus_wdata; n_wr++; end
        else begin bus_rdata = mem[bus_adr]; n_rd++; end
      end else cnt++;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_we = 1'b1; cpu_wdata = d;
    @(negedge clk); cpu_we = 1'b0; cpu_addr = 16'h0000;
    while (bus_stb) @(negedge clk);
  endtask

  task automatic cpu_read(logic [15:0] a, output logic [7:0] d, output int stalls);
    @(negedge clk); cpu_addr = a; cpu_we = 1'b0;
    stalls = 0;
    forever begin
      #(CLK_P/2 - 1);
      if (cpu_rdy) begin d = cpu_rdata; break; end
      stalls++;
      @(negedge clk);
    end
    @(negedge clk); cpu_addr = 16'h0000;
    while (bus_stb) @(negedge clk);
  endtask

  task automatic idx_store(logic [15:0] a, logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_we = 1'b0;
    @(negedge clk); cpu_we = 1'b1; cpu_wdata = d;
    @(negedge clk); cpu_we = 1'b0; cpu_addr = 16'h0000;
    while (bus_stb) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] rb;
    int st, r0, w0;
    logic [31:0] exp;
    for (int i = 0; i < 64; i++) mem[i] = init_word(i);
    bus_rdata = '0; bus_ack = 1'b0;
    cpu_addr = '0; cpu_we = 1'b0; cpu_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    chk("R10 rdy", cpu_rdy, 1);
    chk("R10 stb", bus_stb, 0);
    chk("R10 trig", dbg_trig, 0);

    // R4/R5/R2: fill holding bytes, sweep aligned writes over every word
    cpu_write(16'hFE01, 8'h11);
    cpu_write(16'hFE06, 8'h22);
    cpu_write(16'hFE03, 8'h33);
    for (int w = 0; w < 64; w++) begin
      lat = w % 3;
      cpu_write(16'hFE00 + 16'(4*w), 8'(w) ^ 8'h3C);
      chk("R5 R2 write word", mem[w], {8'h33, 8'h22, 8'h11, 8'(w) ^ 8'h3C});
    end
    chk("R5 write count", n_wr, 64);

    // R4: bit 3 set must not load holding bytes; R3 no strobe for offsets
    w0 = n_wr;
    cpu_write(16'hFE0D, 8'h99);
    cpu_write(16'hFE0E, 8'h98);
    chk("R3 unaligned write no strobe", n_wr, w0);
    cpu_write(16'hFE04, 8'h44);
    chk("R4 bit3 ignored", mem[1], 32'h33221144);

    // R1: off-page write does nothing
    w0 = n_wr;
    cpu_write(16'h1200, 8'h55);
    cpu_write(16'hFD01, 8'h66);
    chk("R1 off page no strobe", n_wr, w0);
    cpu_write(16'hFE00, 8'h77);
    chk("R1 holding untouched", mem[0], 32'h33221177);

    // R6/R7/R2: read sweep with rotating latency
    for (int w = 0; w < 64; w++) begin
      lat = w % 4;
      exp = mem[w];
      cpu_read(16'hFE00 + 16'(4*w), rb, st);
      chk("R6 byte0", rb, exp[7:0]);
      chk("R7 stall cycles", st, lat + 1);
      for (int k = 1; k < 4; k++) begin
        cpu_read(16'hFE00 + 16'(4*w + k), rb, st);
        chk("R6 upper byte", rb, exp[8*k +: 8]);
        chk("R3 no stall unaligned", st, 0);
      end
    end

    // R1: off-page read returns zero, no strobe
    r0 = n_rd;
    cpu_read(16'h3400, rb, st);
    chk("R1 off page read data", rb, 0);
    chk("R1 off page read no strobe", n_rd, r0);

    // R8: read mask
    lat = 1;
    cpu_write(16'hFE0B, 8'h01);
    chk("R9 trig low with 01", dbg_trig, 0);
    r0 = n_rd;
    cpu_read(16'hFE10, rb, st);
    chk("R8 masked read no strobe", n_rd, r0);
    chk("R8 masked read no stall", st, 0);
    w0 = n_wr;
    idx_store(16'hFE14, 8'hAB);
    chk("R8 indexed store no read", n_rd, r0);
    chk("R8 write passes", n_wr, w0 + 1);
    chk("R8 written word", mem[5], 32'h332211AB);

    // R8: unmasked indexed store produces a stray read
    cpu_write(16'hFE0B, 8'h00);
    r0 = n_rd;
    idx_store(16'hFE18, 8'hCD);
    chk("R8 unmasked stray read", n_rd, r0 + 1);

    // R9: trigger follows bit 1
    cpu_write(16'hFE0B, 8'h02);
    chk("R9 trig set", dbg_trig, 1);
    cpu_write(16'hFE07, 8'h00);
    chk("R9 trig held", dbg_trig, 1);
    cpu_write(16'hFE0B, 8'h03);
    chk("R9 trig still set", dbg_trig, 1);
    cpu_write(16'hFE0B, 8'h00);
    chk("R9 trig cleared", dbg_trig, 0);

    finish_run();
  end
endmodule